// File: doc/BRIEF.md
# Paged data address translator

This block turns a 16-bit virtual data address into a 22-bit physical address. The virtual space is split into four fixed 16-Kbyte windows, selected by the top two virtual bits. Each window has its own 8-bit page register. The page register of the selected window becomes the upper physical bits. The 14 low virtual bits pass through to the physical address unchanged. Translation is purely combinational: the physical address appears in the same cycle as the data-access strobe.

Software reaches the four page registers through a byte-wide register-file port, which has an address, a write enable, write data and combinational read data. A relocation mode input chooses where the registers are decoded. With the mode clear they occupy one block of four register addresses. With the mode set they occupy another block of four instead. The page registers are not reset, so software must load all four before it relies on a translation.

Top module: `dpx_xlat`

## Requirements
- R1: While `va_strobe` is 1, `pa[13:0]` equals `va[13:0]`, and `pa[21:14]` equals the page register whose index is `va[15:14]` (0 for 0000h-3FFFh, 1 for 4000h-7FFFh, 2 for 8000h-BFFFh, 3 for C000h-FFFFh).
- R2: `pa_valid` equals `va_strobe` in the same cycle, and `pa` is all zeros while `va_strobe` is 0.
- R3: With `reloc_mode` = 0, page register k sits at register address 240+k (k = 0..3). A write there is stored at the next rising edge, and a read there returns the stored byte on `reg_rdata` in the same cycle.
- R4: With `reloc_mode` = 1, page register k sits at register address 224+k, with the same write and read behaviour as R3.
- R5: An access to the block of four addresses that the current mode does not select (224-227 with the mode clear, 240-243 with the mode set) leaves every page register unchanged and reads back zero.
- R6: An access to any register address outside both blocks leaves every page register unchanged and reads back zero.
- R7: A page register write takes effect at the next rising edge. A translation in the same cycle as the write still uses the old value, and a translation in the following cycle uses the new value.
- R8: While `rst_n` is 0, register writes are ignored. Register contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; page registers load on the rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes, clears nothing |
| reg_addr | input | 8 | Register-file address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, zero on a miss |
| reloc_mode | input | 1 | 0: registers at 240-243; 1: registers at 224-227 |
| va | input | 16 | Virtual data address |
| va_strobe | input | 1 | Data access in progress this cycle |
| pa | output | 22 | Physical address |
| pa_valid | output | 1 | Physical address valid (equals `va_strobe`) |

## Verification
Wrong state can arise in two ways: a write lands in the wrong page register, or a write is accepted that should have been dropped. Either fault shows at once on the ports. The next read of the affected register returns the wrong byte on `reg_rdata`. The next strobed access into that window carries the wrong upper bits on `pa`, one cycle after the faulty edge. A decode fault in the other direction makes a miss address return nonzero data in the very cycle it is presented. Comparing every cycle therefore finds a fault within one clock of the access that exposes it.

// File: rtl/dpx_pkg.sv
`timescale 1ns/1ps
package dpx_pkg;
   localparam int DPX_VA_W      = 16;
   localparam int DPX_PAGE_W    = 8;
   localparam int DPX_NUM_PAGES = 4;
   localparam int DPX_RF_ADDR_W = 8;
   localparam int DPX_BASE_PRI  = 240;
   localparam int DPX_BASE_ALT  = 224;

   typedef enum logic {
      WIN_PRIMARY   = 1'b0,
      WIN_ALTERNATE = 1'b1
   } win_e;
endpackage

// File: rtl/dpx_decode.sv
`timescale 1ns/1ps
module dpx_decode #(
   parameter int ADDR_W    = 8,
   parameter int NUM_PAGES = 4,
   parameter int BASE_PRI  = 240,
   parameter int BASE_ALT  = 224,
   localparam int IDX_W    = $clog2(NUM_PAGES)
) (
   input  logic [ADDR_W-1:0] addr,
   input  dpx_pkg::win_e     win,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);
   localparam logic [ADDR_W-1:0] PRI_A = ADDR_W'(BASE_PRI);
   localparam logic [ADDR_W-1:0] ALT_A = ADDR_W'(BASE_ALT);
   localparam bit ALIGNED = ((BASE_PRI % NUM_PAGES) == 0) &&
                            ((BASE_ALT % NUM_PAGES) == 0) &&
                            ((1 << IDX_W) == NUM_PAGES);

   logic [ADDR_W-1:0] base;
   assign base = (win == dpx_pkg::WIN_ALTERNATE) ? ALT_A : PRI_A;

   generate
      if (ALIGNED) begin : g_aligned
         // blocks start on a multiple of their size: compare the upper bits only
         assign hit = (addr[ADDR_W-1:IDX_W] == base[ADDR_W-1:IDX_W]);
         assign idx = addr[IDX_W-1:0];
      end else begin : g_offset
         logic [ADDR_W-1:0] diff;
         assign diff = addr - base;
         assign hit  = (addr >= base) && (diff < ADDR_W'(NUM_PAGES));
         assign idx  = diff[IDX_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/dpx_page_bank.sv
`timescale 1ns/1ps
module dpx_page_bank #(
   parameter int PAGE_W    = 8,
   parameter int NUM_PAGES = 4,
   localparam int IDX_W    = $clog2(NUM_PAGES)
) (
   input  logic                               clk,
   input  logic                               wr_en,
   input  logic [IDX_W-1:0]                   wr_idx,
   input  logic [PAGE_W-1:0]                  wr_data,
   input  logic [IDX_W-1:0]                   rd_idx,
   output logic [PAGE_W-1:0]                  rd_data,
   output logic [NUM_PAGES-1:0][PAGE_W-1:0]   pages
);
   generate
      for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
         logic sel;
         assign sel = wr_en && (wr_idx == IDX_W'(g));
         // deliberately no reset: contents are undefined until software loads them
         always_ff @(posedge clk) begin
            if (sel) pages[g] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = pages[rd_idx];
endmodule

// File: rtl/dpx_xlat_mux.sv
`timescale 1ns/1ps
module dpx_xlat_mux #(
   parameter int VA_W      = 16,
   parameter int PAGE_W    = 8,
   parameter int NUM_PAGES = 4,
   parameter bit IDLE_ZERO = 1'b1,
   localparam int IDX_W    = $clog2(NUM_PAGES),
   localparam int OFF_W    = VA_W - IDX_W,
   localparam int PA_W     = PAGE_W + OFF_W
) (
   input  logic [VA_W-1:0]                  va,
   input  logic                             va_strobe,
   input  logic [NUM_PAGES-1:0][PAGE_W-1:0] pages,
   output logic [PA_W-1:0]                  pa,
   output logic                             pa_valid
);
   logic [IDX_W-1:0] win_sel;
   logic [PA_W-1:0]  pa_raw;

   assign win_sel  = va[VA_W-1:OFF_W];
   assign pa_raw   = {pages[win_sel], va[OFF_W-1:0]};
   assign pa_valid = va_strobe;

   generate
      if (IDLE_ZERO) begin : g_gated
         assign pa = va_strobe ? pa_raw : '0;
      end else begin : g_open
         assign pa = pa_raw;
      end
   endgenerate
endmodule

// File: rtl/dpx_xlat.sv
`timescale 1ns/1ps
module dpx_xlat #(
   parameter int VA_W      = dpx_pkg::DPX_VA_W,
   parameter int PAGE_W    = dpx_pkg::DPX_PAGE_W,
   parameter int NUM_PAGES = dpx_pkg::DPX_NUM_PAGES,
   parameter int RF_ADDR_W = dpx_pkg::DPX_RF_ADDR_W,
   parameter int BASE_PRI  = dpx_pkg::DPX_BASE_PRI,
   parameter int BASE_ALT  = dpx_pkg::DPX_BASE_ALT,
   parameter bit IDLE_ZERO = 1'b1,
   localparam int IDX_W    = $clog2(NUM_PAGES),
   localparam int PA_W     = PAGE_W + VA_W - IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [RF_ADDR_W-1:0] reg_addr,
   input  logic                 reg_we,
   input  logic [PAGE_W-1:0]    reg_wdata,
   output logic [PAGE_W-1:0]    reg_rdata,
   input  logic                 reloc_mode,
   input  logic [VA_W-1:0]      va,
   input  logic                 va_strobe,
   output logic [PA_W-1:0]      pa,
   output logic                 pa_valid
);
   generate
      if (NUM_PAGES < 2 || (1 << IDX_W) != NUM_PAGES) begin : g_bad_pages
         $error("dpx_xlat: NUM_PAGES must be a power of two, at least 2");
      end
      if (VA_W <= IDX_W) begin : g_bad_va
         $error("dpx_xlat: VA_W too narrow for the window select");
      end
      if (BASE_PRI + NUM_PAGES > (1 << RF_ADDR_W) ||
          BASE_ALT + NUM_PAGES > (1 << RF_ADDR_W)) begin : g_bad_base
         $error("dpx_xlat: register block exceeds the register address range");
      end
      if ((BASE_PRI < BASE_ALT + NUM_PAGES) && (BASE_ALT < BASE_PRI + NUM_PAGES)) begin : g_overlap
         $error("dpx_xlat: primary and alternate register blocks overlap");
      end
   endgenerate

   logic                             rf_hit;
   logic [IDX_W-1:0]                 rf_idx;
   logic [PAGE_W-1:0]                bank_rd;
   logic [NUM_PAGES-1:0][PAGE_W-1:0] page_q;
   logic                             wr_ok;
   dpx_pkg::win_e                    win;

   assign win   = reloc_mode ? dpx_pkg::WIN_ALTERNATE : dpx_pkg::WIN_PRIMARY;
   assign wr_ok = reg_we && rf_hit && rst_n;

   dpx_decode #(
      .ADDR_W    (RF_ADDR_W),
      .NUM_PAGES (NUM_PAGES),
      .BASE_PRI  (BASE_PRI),
      .BASE_ALT  (BASE_ALT)
   ) u_dec (
      .addr (reg_addr),
      .win  (win),
      .hit  (rf_hit),
      .idx  (rf_idx)
   );

   dpx_page_bank #(
      .PAGE_W    (PAGE_W),
      .NUM_PAGES (NUM_PAGES)
   ) u_bank (
      .clk     (clk),
      .wr_en   (wr_ok),
      .wr_idx  (rf_idx),
      .wr_data (reg_wdata),
      .rd_idx  (rf_idx),
      .rd_data (bank_rd),
      .pages   (page_q)
   );

   assign reg_rdata = rf_hit ? bank_rd : '0;

   dpx_xlat_mux #(
      .VA_W      (VA_W),
      .PAGE_W    (PAGE_W),
      .NUM_PAGES (NUM_PAGES),
      .IDLE_ZERO (IDLE_ZERO)
   ) u_mux (
      .va        (va),
      .va_strobe (va_strobe),
      .pages     (page_q),
      .pa        (pa),
      .pa_valid  (pa_valid)
   );
endmodule

// File: rtl/dpx_checker.sv
`timescale 1ns/1ps
module dpx_checker #(
   parameter int VA_W      = dpx_pkg::DPX_VA_W,
   parameter int PAGE_W    = dpx_pkg::DPX_PAGE_W,
   parameter int NUM_PAGES = dpx_pkg::DPX_NUM_PAGES,
   parameter int RF_ADDR_W = dpx_pkg::DPX_RF_ADDR_W,
   parameter int BASE_PRI  = dpx_pkg::DPX_BASE_PRI,
   parameter int BASE_ALT  = dpx_pkg::DPX_BASE_ALT,
   localparam int IDX_W    = $clog2(NUM_PAGES),
   localparam int OFF_W    = VA_W - IDX_W,
   localparam int PA_W     = PAGE_W + OFF_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [RF_ADDR_W-1:0] reg_addr,
   input logic                 reg_we,
   input logic [PAGE_W-1:0]    reg_wdata,
   input logic [PAGE_W-1:0]    reg_rdata,
   input logic                 reloc_mode,
   input logic [VA_W-1:0]      va,
   input logic                 va_strobe,
   input logic [PA_W-1:0]      pa,
   input logic                 pa_valid
);
   int  base_now;
   logic in_block;
   assign base_now = reloc_mode ? BASE_ALT : BASE_PRI;
   assign in_block = (int'(reg_addr) >= base_now) && (int'(reg_addr) < base_now + NUM_PAGES);

   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      va_strobe |-> pa[OFF_W-1:0] == va[OFF_W-1:0]); // R1

   AST_PAGE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (va_strobe && $past(va_strobe) && !$past(reg_we) &&
       va[VA_W-1:OFF_W] == $past(va[VA_W-1:OFF_W]))
      |-> pa[PA_W-1:OFF_W] == $past(pa[PA_W-1:OFF_W])); // R1

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      pa_valid == va_strobe); // R2

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !va_strobe |-> pa == '0); // R2

   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !in_block |-> reg_rdata == '0); // R5

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && in_block) |=>
      (reg_addr != $past(reg_addr) || reloc_mode != $past(reloc_mode) ||
       reg_rdata == $past(reg_wdata))); // R7

   AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we |=>
      (reg_addr != $past(reg_addr) || reloc_mode != $past(reloc_mode) ||
       $stable(reg_rdata))); // R6
endmodule

bind dpx_xlat dpx_checker #(
   .VA_W      (VA_W),
   .PAGE_W    (PAGE_W),
   .NUM_PAGES (NUM_PAGES),
   .RF_ADDR_W (RF_ADDR_W),
   .BASE_PRI  (BASE_PRI),
   .BASE_ALT  (BASE_ALT)
) u_dpx_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_addr   (reg_addr),
   .reg_we     (reg_we),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .reloc_mode (reloc_mode),
   .va         (va),
   .va_strobe  (va_strobe),
   .pa         (pa),
   .pa_valid   (pa_valid)
);

// File: tb/dpx_xlat_tb.sv
`timescale 1ns/1ps
module dpx_xlat_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        reloc_mode = 1'b0;
   logic [15:0] va = '0;
   logic        va_strobe = 1'b0;
   logic [21:0] pa;
   logic        pa_valid;

   always #2.5 clk = ~clk;

   dpx_xlat dut_i (
      .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_we (reg_we),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .reloc_mode (reloc_mode),
      .va (va), .va_strobe (va_strobe), .pa (pa), .pa_valid (pa_valid)
   );

   int   n_checks = 0;
   int   n_fail   = 0;
   int   model [4];
   bit   known [4];
   bit   done = 1'b0;

   function automatic int blk_base(input logic m);
      return m ? 224 : 240;
   endfunction

   task automatic check(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one cycle: drive after the edge, compare at the falling edge, update the model at the next rising edge
   task automatic apply(input logic [7:0] a, input logic we, input logic [7:0] wd,
                        input logic m, input logic [15:0] v, input logic stb, input string tag);
      int  b;
      bit  hit;
      int  k;
      string rt;
      string pt;
      reg_addr = a; reg_we = we; reg_wdata = wd; reloc_mode = m; va = v; va_strobe = stb;
      @(negedge clk);
      b   = blk_base(m);
      hit = (int'(a) >= b) && (int'(a) < b + 4);
      k   = int'(a) - b;
      if (tag != "") rt = tag;
      else if (hit) rt = m ? "R4" : "R3";
      else if (int'(a) >= blk_base(!m) && int'(a) < blk_base(!m) + 4) rt = "R5";
      else rt = "R6";
      pt = (tag != "") ? tag : (stb ? "R1" : "R2");
      if (!hit) check(rt, longint'(reg_rdata), 0);
      else if (known[k]) check(rt, longint'(reg_rdata), longint'(model[k]));
      check(pt, longint'(pa_valid), longint'(stb));
      if (!stb) check(pt, longint'(pa), 0);
      else if (known[v[15:14]])
         check(pt, longint'(pa), (longint'(model[v[15:14]]) << 14) | longint'(v[13:0]));
      @(posedge clk);
      if (we && hit && rst_n) begin
         model[k] = int'(wd);
         known[k] = 1'b1;
      end
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // idle outputs under reset
      apply(8'd100, 1'b0, 8'h00, 1'b0, 16'h1234, 1'b0, "R2");
      rst_n = 1'b1;
      // load all four pages in the primary block
      for (int i = 0; i < 4; i++) apply(8'(240 + i), 1'b1, 8'(8'h11 * (i + 1)), 1'b0, 16'h0, 1'b0, "R3");
      for (int i = 0; i < 4; i++) apply(8'(240 + i), 1'b0, 8'h00, 1'b0, 16'h0, 1'b0, "R3");
      // translations across every window edge
      apply(8'd0, 1'b0, 8'h0, 1'b0, 16'h0000, 1'b1, "R1");
      apply(8'd0, 1'b0, 8'h0, 1'b0, 16'h3FFF, 1'b1, "R1");
      apply(8'd0, 1'b0, 8'h0, 1'b0, 16'h4000, 1'b1, "R1");
      apply(8'd0, 1'b0, 8'h0, 1'b0, 16'h7ABC, 1'b1, "R1");
      apply(8'd0, 1'b0, 8'h0, 1'b0, 16'h8001, 1'b1, "R1");
      apply(8'd0, 1'b0, 8'h0, 1'b0, 16'hBFFF, 1'b1, "R1");
      apply(8'd0, 1'b0, 8'h0, 1'b0, 16'hC000, 1'b1, "R1");
      apply(8'd0, 1'b0, 8'h0, 1'b0, 16'hFFFF, 1'b1, "R1");
      apply(8'd0, 1'b0, 8'h0, 1'b0, 16'hFFFF, 1'b0, "R2");
      // wrong block while clear: writes to 224..227 must be dropped
      for (int i = 0; i < 4; i++) apply(8'(224 + i), 1'b1, 8'hEE, 1'b0, 16'h5555, 1'b1, "R5");
      for (int i = 0; i < 4; i++) apply(8'(240 + i), 1'b0, 8'h00, 1'b0, 16'(i << 14), 1'b1, "R5");
      // relocated block
      for (int i = 0; i < 4; i++) apply(8'(224 + i), 1'b1, 8'(8'hA0 + i * 3), 1'b1, 16'h0, 1'b0, "R4");
      for (int i = 0; i < 4; i++) apply(8'(224 + i), 1'b0, 8'h00, 1'b1, 16'((i << 14) | 16'h0155), 1'b1, "R4");
      for (int i = 0; i < 4; i++) apply(8'(240 + i), 1'b1, 8'h3C, 1'b1, 16'h9999, 1'b1, "R5");
      for (int i = 0; i < 4; i++) apply(8'(224 + i), 1'b0, 8'h00, 1'b1, 16'hE001, 1'b1, "R5");
      // addresses outside both blocks
      apply(8'd223, 1'b1, 8'h77, 1'b1, 16'h0, 1'b0, "R6");
      apply(8'd228, 1'b1, 8'h77, 1'b1, 16'h0, 1'b0, "R6");
      apply(8'd244, 1'b1, 8'h77, 1'b0, 16'h0, 1'b0, "R6");
      apply(8'd239, 1'b1, 8'h77, 1'b0, 16'h0, 1'b0, "R6");
      apply(8'd0,   1'b1, 8'h77, 1'b0, 16'h0, 1'b0, "R6");
      for (int i = 0; i < 4; i++) apply(8'(240 + i), 1'b0, 8'h00, 1'b0, 16'(i << 14), 1'b1, "R6");
      // write and translate in the same cycle, then the next
      apply(8'd241, 1'b1, 8'h5A, 1'b0, 16'h4123, 1'b1, "R7");
      apply(8'd241, 1'b0, 8'h00, 1'b0, 16'h4123, 1'b1, "R7");
      apply(8'd227, 1'b1, 8'hC3, 1'b1, 16'hF00F, 1'b1, "R7");
      apply(8'd227, 1'b0, 8'h00, 1'b1, 16'hF00F, 1'b1, "R7");
      // writes under reset are dropped, contents survive reset
      rst_n = 1'b0;
      apply(8'd242, 1'b1, 8'h0F, 1'b0, 16'h8000, 1'b0, "R8");
      apply(8'd226, 1'b1, 8'h0F, 1'b1, 16'h8000, 1'b0, "R8");
      rst_n = 1'b1;
      apply(8'd242, 1'b0, 8'h00, 1'b0, 16'h8888, 1'b1, "R8");
      apply(8'd226, 1'b0, 8'h00, 1'b1, 16'h8888, 1'b1, "R8");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule